// File: doc/BRIEF.md
# Memory Card Bank Strobe Gate

This block sits on a memory card built from quarter-density DRAMs. The controller sees each row-strobe rank as one deep word space. On the card, each rank is split into four banks. The block turns the controller's active-high row strobes into active-low per-bank row strobes. It decodes two inverted high address bits to choose the bank. It captures that choice at the moment a rank's row strobe asserts, because the bits change before the column strobe arrives. While the refresh-enable strobe is high, the gating is bypassed, so that every bank of each asserted rank sees a row strobe together.

The column strobe is never gated. The card takes the first incoming column strobe line, inverts it and sends it to all of its DRAMs. It passes the remaining lines to the next card slot, each shifted down by one position. The asynchronous board strobes are modelled here as synchronous inputs sampled on a fast clock. Every output is registered, so it reflects the inputs sampled one clock edge earlier.

Top module: `bankRasGate`

## Requirements
- R1: While reset is asserted, every bank row strobe is high (inactive), the card column strobe is high, and every forwarded column line is low.
- R2: With refresh low, a rank whose row strobe is sampled high drives exactly one bank strobe low at the next edge. The bank index is the bitwise inverse of `bankSelN`: index bit 0 comes from `bankSelN[0]` and bit 1 from `bankSelN[1]`. The low output is `bankRasN[rank*4 + index]`.
- R3: The bank index is captured at the first sample where the rank's row strobe is high. Changes to `bankSelN` while that strobe stays high have no effect on the outputs.
- R4: With refresh low, at most one of a rank's four bank strobes is low at any time.
- R5: When refresh was sampled high, all four bank strobes of every rank whose row strobe was sampled high go low at the next edge. Ranks whose row strobe was sampled low stay fully high.
- R6: A rank whose row strobe is sampled low has all four bank strobes high at the next edge. The held bank index is discarded, so the next assertion captures a fresh index.
- R7: `cardCasN` equals the inverse of `casIn[0]` sampled one edge earlier. Row strobes, refresh and bank select do not affect it.
- R8: `casFwd[i]` equals `casIn[i+1]` sampled one edge earlier, for every forwarded line.
- R9: When refresh drops while a rank's row strobe stays high, that rank returns to the single bank captured when its strobe rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rasIn | input | NUM_RANKS (2) | Active-high row strobes of the ranks used by this card |
| casIn | input | CAS_LINES (4) | Active-high column strobes arriving at this slot |
| bankSelN | input | BANK_SEL_W (2) | Inverted high address bits that choose the bank |
| refreshEn | input | 1 | Active-high refresh strobe that bypasses bank gating |
| bankRasN | output | NUM_RANKS*BANKS_PER_RANK (8) | Active-low row strobe per bank, rank-major |
| cardCasN | output | 1 | Active-low column strobe to all DRAMs on the card |
| casFwd | output | CAS_LINES-1 (3) | Active-high column strobes for the next slot, shifted down by one |

## Verification
Most internal faults in this block show up on the bank strobes one edge after the row strobe is first sampled high. An index that is captured wrong, not inverted, or not held shows up as the wrong bank going low. It also shows up on a later cycle of the same strobe when the select inputs are moved mid-access. A held index that is never cleared appears only on the next assertion of that rank. For that reason the stimulus drops a strobe and raises it again with a different select. A refresh override that is missing or that leaks into idle ranks is visible in the same cycle after refresh is sampled. The column strobe paths have no state beyond one register. A wrong bit order there shows on the next edge, under a walk of every column pattern.

// File: rtl/bank_gate_pkg.sv
package bank_gate_pkg;
  // Per-rank strobes handed from control to datapath
  typedef struct packed {
    logic capture;  // first sampled cycle of row strobe: load bank index
    logic active;   // row strobe is high this sample
    logic refresh;  // refresh bypass requested this sample
  } rankStrobe_t;
endpackage

// File: rtl/bgCtrl.sv
module bgCtrl
  import bank_gate_pkg::*;
#(
  parameter int NUM_RANKS = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_RANKS-1:0]          rasIn,
  input  logic                          refreshEn,
  output rankStrobe_t [NUM_RANKS-1:0]   strobes
);
  logic [NUM_RANKS-1:0] rasSeen;

  // Remember the previous row strobe level for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rasSeen <= '0;
    else       rasSeen <= rasIn;
  end

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    always_comb begin
      strobes[r].capture = rasIn[r] & ~rasSeen[r];
      strobes[r].active  = rasIn[r];
      strobes[r].refresh = refreshEn;
    end
  end
endmodule

// File: rtl/bgDatapath.sv
module bgDatapath
  import bank_gate_pkg::*;
#(
  parameter int NUM_RANKS      = 2,
  parameter int BANKS_PER_RANK = 4,
  parameter int CAS_LINES      = 4,
  localparam int BANK_SEL_W    = $clog2(BANKS_PER_RANK),
  localparam int BANK_TOTAL    = NUM_RANKS * BANKS_PER_RANK
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  rankStrobe_t [NUM_RANKS-1:0]   strobes,
  input  logic [BANK_SEL_W-1:0]         bankSelN,
  input  logic [CAS_LINES-1:0]          casIn,
  output logic [BANK_TOTAL-1:0]         bankRasN,
  output logic                          cardCasN,
  output logic [CAS_LINES-2:0]          casFwd
);
  // Bank select arrives inverted; restore true polarity before decode
  logic [BANK_SEL_W-1:0] bankSelTrue;
  assign bankSelTrue = ~bankSelN;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic [BANK_SEL_W-1:0]     bankHeld;
    logic [BANK_SEL_W-1:0]     bankNow;
    logic [BANKS_PER_RANK-1:0] want;

    // Index is held for the whole strobe and dropped when it ends
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                      bankHeld <= '0;
      else if (strobes[r].capture)    bankHeld <= bankSelTrue;
      else if (!strobes[r].active)    bankHeld <= '0;
    end

    assign bankNow = strobes[r].capture ? bankSelTrue : bankHeld;

    for (genvar b = 0; b < BANKS_PER_RANK; b++) begin : g_bank
      assign want[b] = strobes[r].active &
                       (strobes[r].refresh || (bankNow == BANK_SEL_W'(b)));
    end

    // Active-low registered bank strobes
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bankRasN[r*BANKS_PER_RANK +: BANKS_PER_RANK] <= '1;
      else       bankRasN[r*BANKS_PER_RANK +: BANKS_PER_RANK] <= ~want;
    end
  end

  // Column strobe: first line used locally, the rest shifted to next slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cardCasN <= 1'b1;
      casFwd   <= '0;
    end else begin
      cardCasN <= ~casIn[0];
      casFwd   <= casIn[CAS_LINES-1:1];
    end
  end
endmodule

// File: rtl/bankRasGate.sv
module bankRasGate
  import bank_gate_pkg::*;
#(
  parameter int NUM_RANKS      = 2,
  parameter int BANKS_PER_RANK = 4,
  parameter int CAS_LINES      = 4,
  localparam int BANK_SEL_W    = $clog2(BANKS_PER_RANK),
  localparam int BANK_TOTAL    = NUM_RANKS * BANKS_PER_RANK
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_RANKS-1:0]  rasIn,
  input  logic [CAS_LINES-1:0]  casIn,
  input  logic [BANK_SEL_W-1:0] bankSelN,
  input  logic                  refreshEn,
  output logic [BANK_TOTAL-1:0] bankRasN,
  output logic                  cardCasN,
  output logic [CAS_LINES-2:0]  casFwd
);
  rankStrobe_t [NUM_RANKS-1:0] strobes;

  bgCtrl #(.NUM_RANKS(NUM_RANKS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rasIn     (rasIn),
    .refreshEn (refreshEn),
    .strobes   (strobes)
  );

  bgDatapath #(
    .NUM_RANKS      (NUM_RANKS),
    .BANKS_PER_RANK (BANKS_PER_RANK),
    .CAS_LINES      (CAS_LINES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .bankSelN (bankSelN),
    .casIn    (casIn),
    .bankRasN (bankRasN),
    .cardCasN (cardCasN),
    .casFwd   (casFwd)
  );
endmodule

// File: rtl/bgChecker.sv
module bgChecker #(
  parameter int NUM_RANKS      = 2,
  parameter int BANKS_PER_RANK = 4,
  parameter int CAS_LINES      = 4,
  localparam int BANK_SEL_W    = $clog2(BANKS_PER_RANK),
  localparam int BANK_TOTAL    = NUM_RANKS * BANKS_PER_RANK
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_RANKS-1:0]  rasIn,
  input logic [CAS_LINES-1:0]  casIn,
  input logic [BANK_SEL_W-1:0] bankSelN,
  input logic                  refreshEn,
  input logic [BANK_TOTAL-1:0] bankRasN,
  input logic                  cardCasN,
  input logic [CAS_LINES-2:0]  casFwd
);
  // R7: card column strobe follows first incoming line, inverted
  a_r7_card_cas: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (cardCasN == !$past(casIn[0])));

  // R8: remaining lines forwarded shifted down by one
  a_r8_forward: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (casFwd == $past(casIn[CAS_LINES-1:1])));

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    // R4: no more than one bank per rank outside refresh
    a_r4_single_bank: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !$past(refreshEn)) |->
        ($countones(~bankRasN[r*BANKS_PER_RANK +: BANKS_PER_RANK]) <= 1));

    // R5: refresh drives every bank of an asserted rank
    a_r5_refresh_all: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(refreshEn) && $past(rasIn[r])) |->
        (bankRasN[r*BANKS_PER_RANK +: BANKS_PER_RANK] == '0));

    // R6: idle rank keeps every bank strobe inactive
    a_r6_idle_rank: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !$past(rasIn[r])) |->
        (bankRasN[r*BANKS_PER_RANK +: BANKS_PER_RANK] == '1));

    // R3: held strobe without refresh keeps the same bank
    a_r3_hold_bank: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(rstN, 2) && $past(rasIn[r]) && $past(rasIn[r], 2) &&
       !$past(refreshEn) && !$past(refreshEn, 2)) |->
        $stable(bankRasN[r*BANKS_PER_RANK +: BANKS_PER_RANK]));
  end
endmodule

bind bankRasGate bgChecker #(
  .NUM_RANKS      (NUM_RANKS),
  .BANKS_PER_RANK (BANKS_PER_RANK),
  .CAS_LINES      (CAS_LINES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rasIn     (rasIn),
  .casIn     (casIn),
  .bankSelN  (bankSelN),
  .refreshEn (refreshEn),
  .bankRasN  (bankRasN),
  .cardCasN  (cardCasN),
  .casFwd    (casFwd)
);

// File: tb/bankRasGate_tb.sv
module bankRasGate_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] rasIn = '0;
  logic [3:0] casIn = '0;
  logic [1:0] bankSelN = '1;
  logic       refreshEn = 1'b0;
  logic [7:0] bankRasN;
  logic       cardCasN;
  logic [2:0] casFwd;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // Behavioural reference state
  int heldBank [2];
  bit heldOn   [2];
  logic [7:0] expRas = '1;
  logic       expCas = 1'b1;
  logic [2:0] expFwd = '0;

  always #2.5 clk = ~clk;  // 200 MHz

  bankRasGate u_dut (
    .clk(clk), .rstN(rstN), .rasIn(rasIn), .casIn(casIn),
    .bankSelN(bankSelN), .refreshEn(refreshEn),
    .bankRasN(bankRasN), .cardCasN(cardCasN), .casFwd(casFwd)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic compare(input string tag);
    checks++;
    if (bankRasN !== expRas) begin
      fails++;
      $display("FAIL %s bankRasN actual %b expected %b", tag, bankRasN, expRas);
    end
    checks++;
    if (cardCasN !== expCas) begin
      fails++;
      $display("FAIL R7 cardCasN actual %b expected %b", cardCasN, expCas);
    end
    checks++;
    if (casFwd !== expFwd) begin
      fails++;
      $display("FAIL R8 casFwd actual %b expected %b", casFwd, expFwd);
    end
  endtask

  // One clock: model the sampled inputs, then check just after the edge
  task automatic cycle(input string tag);
    @(posedge clk);
    for (int r = 0; r < 2; r++) begin
      if (rasIn[r] && !heldOn[r]) begin
        heldBank[r] = 3 - int'(bankSelN);
        heldOn[r]   = 1'b1;
      end else if (!rasIn[r]) begin
        heldOn[r] = 1'b0;
      end
      for (int b = 0; b < 4; b++)
        expRas[r*4+b] = !(rasIn[r] && (refreshEn || b == heldBank[r]));
    end
    expCas = !casIn[0];
    expFwd = casIn[3:1];
    #1;
    compare(tag);
  endtask

  initial begin
    heldBank[0] = 0; heldBank[1] = 0;
    heldOn[0] = 0;   heldOn[1] = 0;
    casIn = 4'b1111;
    rasIn = 2'b11;
    refreshEn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    compare("R1");  // reset values held despite active inputs
    @(negedge clk);
    rstN = 1'b1;
    rasIn = '0; refreshEn = 1'b0; casIn = '0;
    cycle("R6");

    // R2: every bank index on each rank
    for (int r = 0; r < 2; r++) begin
      for (int s = 0; s < 4; s++) begin
        bankSelN = 2'(s);
        rasIn = 2'(1 << r);
        cycle("R2");
        cycle("R2");
        rasIn = '0;
        cycle("R6");
      end
    end

    // R3: select moves while strobe held
    bankSelN = 2'b10;            // bank 1
    rasIn = 2'b01;
    cycle("R3");
    for (int s = 0; s < 4; s++) begin
      bankSelN = 2'(s);
      cycle("R3");
    end
    // R6: drop and re-raise with a different index
    rasIn = '0;
    cycle("R6");
    rasIn = 2'b01;               // bankSelN = 3 -> bank 0
    cycle("R6");
    bankSelN = 2'b00;
    cycle("R3");
    rasIn = '0;
    cycle("R6");

    // Both ranks, differing captures (R2, R4)
    bankSelN = 2'b01;            // bank 2 for rank 0
    rasIn = 2'b01;
    cycle("R4");
    bankSelN = 2'b11;            // bank 0 for rank 1
    rasIn = 2'b11;
    cycle("R4");
    cycle("R4");

    // R5 then R9: refresh mid-access, then back to held banks
    refreshEn = 1'b1;
    cycle("R5");
    cycle("R5");
    refreshEn = 1'b0;
    cycle("R9");
    cycle("R9");
    rasIn = '0;
    cycle("R6");

    // R5: refresh with only rank 1 and with no rank
    refreshEn = 1'b1;
    rasIn = 2'b10;
    cycle("R5");
    rasIn = 2'b00;
    cycle("R5");
    refreshEn = 1'b0;
    cycle("R6");

    // R7/R8: walk every column pattern under varied row activity
    for (int c = 0; c < 16; c++) begin
      casIn = 4'(c);
      rasIn = 2'(c % 4);
      refreshEn = c[2];
      bankSelN = 2'(c / 4);
      cycle("R7");
    end
    rasIn = '0; casIn = '0; refreshEn = 1'b0;
    cycle("R8");
    cycle("R8");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule